// File: doc/BRIEF.md
# Normalized Long Divider, 64 by 32 Bits

This block divides an unsigned 64-bit dividend, given as a high and a low 32-bit word, by an unsigned 32-bit divisor. It returns a 32-bit quotient and a 32-bit remainder. A caller raises `start` for one cycle while the block is idle. The block then holds `busy` high, pulses `done` for one cycle when the result is ready, and keeps the result on its outputs until the next operation completes.

The block does not retire one quotient bit at a time. It first shifts the divisor left until its top bit is set, and shifts the dividend by the same amount. It then forms the quotient as two 16-bit digits. For each digit, a first estimate comes from dividing the current partial remainder by the upper half of the normalized divisor. A small correction network then lowers that estimate until it is exact. The remainder is shifted back right at the end.

When the quotient cannot fit in 32 bits (the high dividend word is at least the divisor), the block reports overflow with both outputs all ones. A zero divisor always falls under this rule.

Top module: `norm_udiv`

## Requirements
- R1: While reset is held, `busy`, `done`, `quot` and `rem` are all 0.
- R2: If `dvd_hi >= dvsr` when an operation is accepted, the result is `quot = 0xFFFFFFFF` and `rem = 0xFFFFFFFF`. `done` is high in the cycle after the first clock edge that follows the accepting edge.
- R3: A divisor of zero produces the overflow result of R2, whatever the dividend.
- R4: Otherwise, `quot` equals floor({dvd_hi,dvd_lo} / dvsr) and `rem` equals {dvd_hi,dvd_lo} mod dvsr, both exact.
- R5: For a non-overflow operation, `done` goes high exactly 37 clock edges after the accepting edge.
- R6: `busy` rises at the accepting edge and falls at the edge where `done` rises. `done` lasts exactly one cycle and is never high together with `busy`.
- R7: `start` is ignored while `busy` is high. Operand changes during an operation do not alter its result, and no second operation is queued.
- R8: `quot` and `rem` keep their value from one `done` pulse until the next, whatever the inputs do in between.
- R9: Results are exact for divisors with every leading-zero count from 0 to 31. This includes no shift (top bit set) and the largest shift (divisor 1).
- R10: Results are exact when a first digit estimate is too large, including cases where the estimate reaches 65536 and the correction must be applied more than once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a division; accepted only while idle |
| dvd_hi | input | 32 | Upper word of the dividend |
| dvd_lo | input | 32 | Lower word of the dividend |
| dvsr | input | 32 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| quot | output | 32 | Quotient, held until the next completion |
| rem | output | 32 | Remainder, held until the next completion |

## Verification
The hardest situation to reach is a digit estimate that is too large by two, or one that reaches 65536. Random operands almost never produce either case. Both need a dividend high word just below the divisor and a normalized divisor whose upper digit is small compared with its lower digit. The stimulus therefore builds such operands on purpose: divisors near 0x8000_FFFF with a high word of divisor minus one. It also sweeps the divisor's leading one across all 32 positions, so every shift amount, including none, is exercised.

// File: rtl/ndiv_pkg.sv
// Shared definitions for the normalized long divider.
// Assumes nothing beyond the standard types.
package ndiv_pkg;

    // Sequencer states of the divider control.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_EST1,
        ST_FIX1,
        ST_EST2,
        ST_FIX2
    } ndiv_state_t;

endpackage

// File: rtl/ndiv_lzc.sv
// Leading-zero counter for the divisor.
// Output is the number of zero bits above the highest set bit.
// Assumes the input is nonzero; for zero the output is not meaningful.
module ndiv_lzc #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    output logic [SW-1:0] cnt
);

    // Priority search from the top bit down.
    always_comb begin
        logic found;
        found = 1'b0;
        cnt   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && val[i]) begin
                cnt   = SW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ndiv_est.sv
// Iterative digit estimator: divides an NW-bit partial remainder by a
// DW-bit divisor digit, one quotient bit per step, over DW+1 steps.
// Assumes the divisor digit has its top bit set, and that the numerator
// divided by it fits in DW+1 bits.
module ndiv_est #(
    parameter int NW = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [DW:0]   q,
    output logic [DW-1:0] rem
);

    logic [DW-1:0] rem_q;
    logic [DW:0]   q_q;
    logic [DW:0]   bits_q;
    logic [DW-1:0] den_q;
    logic [DW:0]   trial;
    logic [DW:0]   diff;
    logic          fits;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        trial = {rem_q, bits_q[DW]};
        fits  = trial >= {1'b0, den_q};
        diff  = trial - {1'b0, den_q};
    end

    // Load the operands, then shift in one numerator bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            q_q    <= '0;
            bits_q <= '0;
            den_q  <= '0;
        end else if (load) begin
            rem_q  <= DW'(num[NW-1:DW+1]);
            q_q    <= '0;
            bits_q <= num[DW:0];
            den_q  <= den;
        end else if (step) begin
            rem_q  <= fits ? diff[DW-1:0] : trial[DW-1:0];
            q_q    <= {q_q[DW-1:0], fits};
            bits_q <= bits_q << 1;
        end
    end

    assign q   = q_q;
    assign rem = rem_q;

    // R10: the running remainder stays below the divisor digit after each step.
    a_r10_est_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q < den_q));

endmodule

// File: rtl/ndiv_fix.sv
// Digit correction network: lowers an estimated quotient digit until
// estimate * low divisor digit no longer exceeds rhat:next digit.
// Each unrolled stage stops once the estimate is in range or rhat
// reaches the digit base. Assumes a normalized divisor, for which
// two stages always suffice.
module ndiv_fix #(
    parameter int DW = 16,
    localparam int NSTAGE = 2,
    localparam int PW = 2 * DW + 2
) (
    input  logic [DW:0]   qhat,
    input  logic [DW-1:0] rhat,
    input  logic [DW-1:0] vhi,
    input  logic [DW-1:0] vlo,
    input  logic [DW-1:0] nxt,
    output logic [DW:0]   qout
);

    logic [DW:0] qs   [NSTAGE+1];
    logic [DW:0] rs   [NSTAGE+1];
    logic        live [NSTAGE+1];

    assign qs[0]   = qhat;
    assign rs[0]   = {1'b0, rhat};
    assign live[0] = 1'b1;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        logic [PW-1:0] prod;
        logic [PW-1:0] lim;
        logic          dec;
        logic [DW:0]   rnext;
        // One correction stage: test, decrement, widen rhat.
        always_comb begin
            prod  = PW'(qs[k]) * PW'(vlo);
            lim   = PW'({rs[k], nxt});
            dec   = live[k] && (qs[k][DW] || (prod > lim));
            rnext = rs[k] + {1'b0, vhi};
        end
        assign qs[k+1]   = dec ? qs[k] - 1'b1 : qs[k];
        assign rs[k+1]   = dec ? rnext : rs[k];
        assign live[k+1] = dec && !rnext[DW];
    end

    assign qout = qs[NSTAGE];

endmodule

// File: rtl/norm_udiv.sv
// Normalized 64-by-32 unsigned divider with start/busy/done handshake.
// Normalizes the divisor, then produces two quotient digits, each
// estimated by ndiv_est and corrected by ndiv_fix. A high dividend word
// at or above the divisor (including a zero divisor) returns all ones.
// Assumes start is only meaningful while busy is low.
module norm_udiv
    import ndiv_pkg::*;
#(
    parameter int W = 32,
    localparam int DW = W / 2,
    localparam int SW = $clog2(W),
    localparam int CW = $clog2(DW + 1),
    localparam int XW = W + DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvsr,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);

    ndiv_state_t   st;
    logic [W-1:0]  hi_q, lo_q, d_q;
    logic [SW-1:0] sh_q;
    logic [W-1:0]  vn_q, un10_q, un32_q, un21_q;
    logic [DW-1:0] q1_q;
    logic [CW-1:0] cnt_q;

    logic [SW-1:0] lz;
    logic [W-1:0]  vn_c, un32_c, un10_c;
    logic          ovf_c;
    logic [DW:0]   est_q;
    logic [DW-1:0] est_rem;
    logic [DW:0]   fix_q;
    logic [W-1:0]  est_num;
    logic [DW-1:0] est_den;
    logic [DW-1:0] fix_nxt;
    logic          est_load, est_step;
    logic [XW-1:0] wide1, wide2;
    logic [W-1:0]  un21_c, rem_c;

    ndiv_lzc #(.W(W)) u_lzc (
        .val (d_q),
        .cnt (lz)
    );

    // Normalization shifts of divisor and dividend.
    always_comb begin
        ovf_c  = hi_q >= d_q;
        vn_c   = d_q << lz;
        un10_c = lo_q << lz;
        un32_c = (hi_q << lz) | ((lz == '0) ? '0 : (lo_q >> (W - int'(lz))));
    end

    // Operand routing into the shared estimator and correction network.
    always_comb begin
        est_load = ((st == ST_NORM) && !ovf_c) || (st == ST_FIX1);
        est_step = (st == ST_EST1) || (st == ST_EST2);
        est_num  = (st == ST_NORM) ? un32_c : un21_c;
        est_den  = (st == ST_NORM) ? vn_c[W-1:DW] : vn_q[W-1:DW];
        fix_nxt  = (st == ST_FIX1) ? un10_q[W-1:DW] : un10_q[DW-1:0];
    end

    ndiv_est #(.NW(W), .DW(DW)) u_est (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (est_load),
        .step  (est_step),
        .num   (est_num),
        .den   (est_den),
        .q     (est_q),
        .rem   (est_rem)
    );

    ndiv_fix #(.DW(DW)) u_fix (
        .qhat (est_q),
        .rhat (est_rem),
        .vhi  (vn_q[W-1:DW]),
        .vlo  (vn_q[DW-1:0]),
        .nxt  (fix_nxt),
        .qout (fix_q)
    );

    // Multiply-and-subtract for the partial remainder and the final remainder.
    always_comb begin
        wide1  = {un32_q, un10_q[W-1:DW]}
               - ({{W{1'b0}}, fix_q[DW-1:0]} * {{DW{1'b0}}, vn_q});
        wide2  = {un21_q, un10_q[DW-1:0]}
               - ({{W{1'b0}}, fix_q[DW-1:0]} * {{DW{1'b0}}, vn_q});
        un21_c = wide1[W-1:0];
        rem_c  = wide2[W-1:0] >> sh_q;
    end

    // Sequencer: accept, normalize, two estimate/correct rounds, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            busy   <= 1'b0;
            done   <= 1'b0;
            quot   <= '0;
            rem    <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            d_q    <= '0;
            sh_q   <= '0;
            vn_q   <= '0;
            un10_q <= '0;
            un32_q <= '0;
            un21_q <= '0;
            q1_q   <= '0;
            cnt_q  <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        hi_q <= dvd_hi;
                        lo_q <= dvd_lo;
                        d_q  <= dvsr;
                        busy <= 1'b1;
                        st   <= ST_NORM;
                    end
                end
                ST_NORM: begin
                    if (ovf_c) begin
                        quot <= '1;
                        rem  <= '1;
                        done <= 1'b1;
                        busy <= 1'b0;
                        st   <= ST_IDLE;
                    end else begin
                        sh_q   <= lz;
                        vn_q   <= vn_c;
                        un10_q <= un10_c;
                        un32_q <= un32_c;
                        cnt_q  <= '0;
                        st     <= ST_EST1;
                    end
                end
                ST_EST1: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(DW)) st <= ST_FIX1;
                end
                ST_FIX1: begin
                    q1_q   <= fix_q[DW-1:0];
                    un21_q <= un21_c;
                    cnt_q  <= '0;
                    st     <= ST_EST2;
                end
                ST_EST2: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(DW)) st <= ST_FIX2;
                end
                ST_FIX2: begin
                    quot <= {q1_q, fix_q[DW-1:0]};
                    rem  <= rem_c;
                    done <= 1'b1;
                    busy <= 1'b0;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R6: done is a single-cycle pulse.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done and busy are never high together.
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: busy only rises in response to a start request.
    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R4: a completed remainder is below the divisor unless overflow was flagged.
    a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rem < d_q) || ((quot == '1) && (rem == '1))));

    // R9: the normalized divisor always has its top bit set while estimating.
    a_r9_norm_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EST1) |-> vn_q[W-1]);

    // R10: after correction every quotient digit fits in one digit.
    a_r10_digit_fits: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_FIX1) || (st == ST_FIX2)) |-> !fix_q[DW]);

endmodule

// File: tb/norm_udiv_bench.sv
// Self-checking bench: a behavioural cycle model compared every clock.
module norm_udiv_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
    logic        busy, done;
    logic [31:0] quot, rem;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;
    string tag = "R4";

    norm_udiv u_norm_udiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .dvd_hi (dvd_hi),
        .dvd_lo (dvd_lo),
        .dvsr   (dvsr),
        .busy   (busy),
        .done   (done),
        .quot   (quot),
        .rem    (rem)
    );

    always #10ns clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: latency counters plus a 64-bit divide.
    bit          mb = 1'b0, md = 1'b0, movf = 1'b0;
    int          mcnt = 0;
    logic [31:0] mq = '0, mr = '0, pq = '0, pr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mb = 1'b0; md = 1'b0; mcnt = 0; mq = '0; mr = '0;
        end else begin
            md = 1'b0;
            if (mb) begin
                mcnt--;
                if (mcnt == 0) begin
                    mb = 1'b0; md = 1'b1; mq = pq; mr = pr;
                end
            end else if (start) begin
                logic [63:0] n;
                n = {dvd_hi, dvd_lo};
                movf = (dvd_hi >= dvsr);
                if (movf) begin
                    pq = '1; pr = '1; mcnt = 1;
                end else begin
                    pq = 32'(n / {32'd0, dvsr});
                    pr = 32'(n % {32'd0, dvsr});
                    mcnt = 37;
                end
                mb = 1'b1;
            end
        end
    end

    // Compare the design with the model away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            check(busy === mb, "R6", {31'd0, busy}, {31'd0, mb});
            check(done === md, movf ? "R2" : "R5", {31'd0, done}, {31'd0, md});
            check(quot === mq, md ? tag : "R8", quot, mq);
            check(rem === mr, md ? tag : "R8", rem, mr);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One operation; poke drives extra start requests while busy (R7).
    task automatic do_op(input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] d, input string t, input bit poke);
        @(negedge clk);
        tag = t;
        dvd_hi = hi; dvd_lo = lo; dvsr = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            for (int i = 0; i < 10 && busy; i++) begin
                dvd_hi = $urandom; dvd_lo = $urandom; dvsr = $urandom;
                start = 1'b1;
                @(negedge clk);
            end
            start = 1'b0;
        end
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        if (busy) check(1'b0, "watchdog", 32'd1, 32'd0);
        // R8: scramble the operand inputs while idle; outputs must hold.
        dvd_hi = $urandom; dvd_lo = $urandom; dvsr = $urandom;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20ns);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] h, l, d;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(busy === 1'b0, "R1", {31'd0, busy}, 32'd0);
        check(done === 1'b0, "R1", {31'd0, done}, 32'd0);
        check(quot === 32'd0, "R1", quot, 32'd0);
        check(rem === 32'd0, "R1", rem, 32'd0);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R4: basic values.
        do_op(32'd0, 32'd123, 32'd10, "R4", 1'b0);
        do_op(32'd0, 32'd7, 32'd7, "R4", 1'b0);
        do_op(32'h0000_0001, 32'h0000_0000, 32'd3, "R4", 1'b0);
        // R2: overflow, equal and greater high word.
        do_op(32'd5, 32'd0, 32'd5, "R2", 1'b0);
        do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678, "R2", 1'b0);
        // R3: zero divisor.
        do_op(32'd0, 32'd0, 32'd0, "R3", 1'b0);
        do_op(32'h0000_0000, 32'hDEAD_BEEF, 32'd0, "R3", 1'b0);
        // R10: estimates that need one or two corrections.
        do_op(32'h8000_FFFE, 32'hFFFF_FFFF, 32'h8000_FFFF, "R10", 1'b0);
        do_op(32'h8000_0000, 32'h0000_0000, 32'h8000_0001, "R10", 1'b0);
        do_op(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10", 1'b0);
        do_op(32'h7FFF_8000, 32'h0000_0000, 32'h8000_0000, "R10", 1'b0);
        do_op(32'h0000_FFFF, 32'hFFFF_0000, 32'h0001_FFFF, "R10", 1'b0);
        do_op(32'h0001_0000, 32'h0000_FFFF, 32'h0001_FFFE, "R10", 1'b0);
        // R9: every leading-zero count, including s = 0 and s = 31.
        for (int k = 0; k < 32; k++) begin
            d = (32'd1 << k) | (32'($urandom) & ((32'd1 << k) - 32'd1));
            h = d >> 1;
            l = $urandom;
            do_op(h, l, d, "R9", 1'b0);
        end
        do_op(32'd0, 32'hFFFF_FFFF, 32'd1, "R9", 1'b0);
        // R7: start requests while busy are ignored.
        do_op(32'h0000_1234, 32'h5678_9ABC, 32'h0001_0003, "R7", 1'b1);
        do_op(32'h00FF_0000, 32'h0000_0001, 32'h0F00_0000, "R7", 1'b1);
        // R4: random operands, mostly non-overflow.
        for (int i = 0; i < 200; i++) begin
            d = $urandom;
            h = $urandom;
            l = $urandom;
            if ((i % 8) != 0 && d != 0) h = h % d;
            do_op(h, l, d, "R4", 1'b0);
        end
        finish_run();
    end

endmodule